// File: doc/BRIEF.md
# Clock Output Gating and Power-Down Sequencer

This block sits at the output side of a multi-output clock generator. It takes the already divided clocks for seven output groups and drives them to the pins: four CPU clocks, three interrupt-controller clocks, three 66 MHz clocks, eleven PCI clocks, two reference clocks, a fixed 48 MHz clock and a mixed 24/48 MHz clock. It does not synthesize or modulate any clock. It gates each output with its own enable and stops that output low without a runt pulse. It can also float every output at once.

An asynchronous active-low power-down request is synchronized into the control domain, which runs on the free-running PCI source clock. While power-down is requested, each output parks low on its own next falling edge. The VCO enable drops only after feedback confirms that every output has parked, and the oscillator enable drops one cycle later. On wake-up, both enables return together. The outputs then stay quiet for a programmable number of control cycles, so the synthesizer can settle, before they restart with full-width pulses.

Top module: `clk_out_gate`

## Requirements
- R1: While `rst_n` is low, every clock output is low and `vco_en` and `osc_en` are low.
- R2: After `pd_n` goes low, which is seen through a two-stage synchronizer, each output stops in the low state at the next falling edge of its own source clock. No output rises again while power-down is held.
- R3: `vco_en` falls only when every output is parked. `osc_en` falls exactly one control-clock cycle after `vco_en`.
- R4: When `pd_n` rises, `vco_en` and `osc_en` rise in the same cycle. The outputs then remain low for `wake_wait`+1 control cycles. A PCI output first rises exactly `wake_wait`+2 control cycles after the enables rise.
- R5: Mask bit i of a group drives output bit i of that group. A 0 holds that output static low, and a 1 lets it toggle with its source.
- R6: A PCI mask change appears at the output no later than the second rising edge of `clk_pci` after the change.
- R7: While `tri_all` is 1, every clock output is high-impedance and none drives high. When `tri_all` returns to 0, the outputs resume.
- R8: With `sel_24` = 0, `mix_o` carries the 48 MHz source. With `sel_24` = 1, it carries the 48 MHz source divided by two. `sel_24` is treated as static while `mix_o` runs.
- R9: Gating never shortens a pulse. The first high phase after enabling lasts the full high phase of the source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_cpu | input | 1 | CPU group source clock |
| clk_apic | input | 1 | Interrupt-controller group source clock |
| clk_v66 | input | 1 | 66 MHz group source clock |
| clk_pci | input | 1 | Free-running PCI source; also the control clock |
| clk_ref | input | 1 | Reference group source clock |
| clk_48 | input | 1 | 48 MHz source clock |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| cpu_en | input | N_CPU | CPU output enables |
| apic_en | input | N_APIC | Interrupt-controller output enables |
| v66_en | input | N_V66 | 66 MHz output enables |
| pci_en | input | N_PCI | PCI output enables |
| ref_en | input | N_REF | Reference output enables |
| usb_en | input | 1 | Fixed 48 MHz output enable |
| mix_en | input | 1 | 24/48 MHz output enable |
| tri_all | input | 1 | Float all clock outputs |
| sel_24 | input | 1 | 1 selects 24 MHz on `mix_o` |
| wake_wait | input | WAIT_W | Settle wait in control cycles after wake-up |
| cpu_o | output | N_CPU | CPU clocks |
| apic_o | output | N_APIC | Interrupt-controller clocks |
| v66_o | output | N_V66 | 66 MHz clocks |
| pci_o | output | N_PCI | PCI clocks |
| ref_o | output | N_REF | Reference clocks |
| usb_o | output | 1 | Fixed 48 MHz clock |
| mix_o | output | 1 | 24 or 48 MHz clock |
| vco_en | output | 1 | VCO enable |
| osc_en | output | 1 | Crystal oscillator enable |

## Verification
The assertions check four things on every control cycle: that `vco_en` never drops while any gate enable is still set, that the oscillator enable follows the VCO enable, that outputs stay quiet while the VCO is off, and that run mode is entered only with both enables up. They also check, on each falling edge, that a PCI output whose registered mask was 0 produces no high phase. Other behaviours can only be shown by the bench's timed scenarios: the exact wake-up delay for two wait values, the two-edge mask latency, the full-width first pulse, the frequency ratio of the 24/48 output, and the floating of outputs. A walking-zero and walking-one sweep over all 25 mask bits shows that each mask bit controls its own output and no other.

// File: rtl/clk_out_gate.sv
`timescale 1ns/100ps
module clk_out_gate #(
  parameter int N_CPU  = 4,
  parameter int N_APIC = 3,
  parameter int N_V66  = 3,
  parameter int N_PCI  = 11,
  parameter int N_REF  = 2,
  parameter int WAIT_W = 16
) (
  input  logic              rst_n,
  input  logic              clk_cpu,
  input  logic              clk_apic,
  input  logic              clk_v66,
  input  logic              clk_pci,
  input  logic              clk_ref,
  input  logic              clk_48,
  input  logic              pd_n,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_APIC-1:0] apic_en,
  input  logic [N_V66-1:0]  v66_en,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_REF-1:0]  ref_en,
  input  logic              usb_en,
  input  logic              mix_en,
  input  logic              tri_all,
  input  logic              sel_24,
  input  logic [WAIT_W-1:0] wake_wait,
  output wire  [N_CPU-1:0]  cpu_o,
  output wire  [N_APIC-1:0] apic_o,
  output wire  [N_V66-1:0]  v66_o,
  output wire  [N_PCI-1:0]  pci_o,
  output wire  [N_REF-1:0]  ref_o,
  output wire               usb_o,
  output wire               mix_o,
  output logic              vco_en,
  output logic              osc_en
);
  localparam int NT   = N_CPU + N_APIC + N_V66 + N_PCI + N_REF + 2;
  localparam int O_AP = N_CPU;
  localparam int O_66 = O_AP + N_APIC;
  localparam int O_PC = O_66 + N_V66;
  localparam int O_RF = O_PC + N_PCI;
  localparam int O_48 = O_RF + N_REF;
  localparam int O_MX = O_48 + 1;

  typedef enum logic [2:0] {S_OFF, S_WAKE, S_RUN, S_PARK, S_VCOOFF} state_t;

  state_t            st;
  logic [WAIT_W-1:0] cnt;
  logic              pd_s1, pd_s2, park_s1, park_s2, div2, run_ok;
  logic [NT-1:0]     mask_q, en_q, src, gated;

  wire mix_src = sel_24 ? div2 : clk_48;
  assign src = {mix_src, clk_48, {N_REF{clk_ref}}, {N_PCI{clk_pci}},
                {N_V66{clk_v66}}, {N_APIC{clk_apic}}, {N_CPU{clk_cpu}}};

  always_ff @(posedge clk_48 or negedge rst_n)
    if (!rst_n) div2 <= 1'b0;
    else        div2 <= ~div2;

  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) begin
      {pd_s2, pd_s1}     <= '0;
      {park_s2, park_s1} <= 2'b11;
      mask_q             <= '0;
    end else begin
      {pd_s2, pd_s1}     <= {pd_s1, pd_n};
      {park_s2, park_s1} <= {park_s1, ~|en_q};
      mask_q <= {mix_en, usb_en, ref_en, pci_en, v66_en, apic_en, cpu_en};
    end

  always_ff @(posedge clk_pci or negedge rst_n)
    if (!rst_n) begin
      st  <= S_OFF;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF:  if (pd_s2) begin st <= S_WAKE; cnt <= wake_wait; end
        S_WAKE: if (!pd_s2)        st  <= S_VCOOFF;
                else if (cnt == 0) st  <= S_RUN;
                else               cnt <= cnt - 1'b1;
        S_RUN:  if (!pd_s2) begin st <= S_PARK; cnt <= WAIT_W'(2); end
        S_PARK: if (cnt != 0)      cnt <= cnt - 1'b1;
                else if (park_s2)  st  <= S_VCOOFF;
        default: st <= S_OFF;
      endcase
    end

  assign run_ok = (st == S_RUN);
  assign vco_en = (st == S_WAKE) || (st == S_RUN) || (st == S_PARK);
  assign osc_en = (st != S_OFF);

  for (genvar i = 0; i < NT; i++) begin : g_gate
    wire  sclk = src[i];
    logic q;
    always_ff @(negedge sclk or negedge rst_n)
      if (!rst_n) q <= 1'b0;
      else        q <= run_ok & mask_q[i];
    assign en_q[i] = q;
  end

  assign gated = src & en_q;

  assign cpu_o  = tri_all ? 'z   : gated[O_AP-1:0];
  assign apic_o = tri_all ? 'z   : gated[O_66-1:O_AP];
  assign v66_o  = tri_all ? 'z   : gated[O_PC-1:O_66];
  assign pci_o  = tri_all ? 'z   : gated[O_RF-1:O_PC];
  assign ref_o  = tri_all ? 'z   : gated[O_48-1:O_RF];
  assign usb_o  = tri_all ? 1'bz : gated[O_48];
  assign mix_o  = tri_all ? 1'bz : gated[O_MX];
endmodule

// File: rtl/clk_out_gate_chk.sv
`timescale 1ns/100ps
module clk_out_gate_chk #(
  parameter int NT    = 25,
  parameter int N_PCI = 11
) (
  input logic             rst_n,
  input logic             clk_pci,
  input logic             vco_en,
  input logic             osc_en,
  input logic             run_ok,
  input logic [NT-1:0]    en_q,
  input logic [NT-1:0]    gated,
  input logic [N_PCI-1:0] mask_pci,
  input logic [N_PCI-1:0] gated_pci
);
  assert_park_before_vco_R3: assert property (@(posedge clk_pci) disable iff (!rst_n)
    $fell(vco_en) |-> (en_q == '0));

  assert_osc_after_vco_R3: assert property (@(posedge clk_pci) disable iff (!rst_n)
    $fell(osc_en) |-> !$past(vco_en));

  assert_quiet_when_off_R2: assert property (@(posedge clk_pci) disable iff (!rst_n)
    !vco_en |-> (gated == '0));

  assert_run_after_enables_R4: assert property (@(posedge clk_pci) disable iff (!rst_n)
    $rose(run_ok) |-> ($past(vco_en) && $past(osc_en)));

  assert_mask_holds_low_R5: assert property (@(negedge clk_pci) disable iff (!rst_n)
    ((~$past(mask_pci)) & gated_pci) == '0);
endmodule

bind clk_out_gate clk_out_gate_chk #(.NT(NT), .N_PCI(N_PCI)) u_chk (
  .rst_n    (rst_n),
  .clk_pci  (clk_pci),
  .vco_en   (vco_en),
  .osc_en   (osc_en),
  .run_ok   (run_ok),
  .en_q     (en_q),
  .gated    (gated),
  .mask_pci (mask_q[O_PC +: N_PCI]),
  .gated_pci(gated[O_PC +: N_PCI])
);

// File: tb/tb_clk_out_gate.sv
`timescale 1ns/100ps
module tb_clk_out_gate;
  localparam int NT = 25;
  localparam int PC = 10;

  logic rst_n = 0, pd_n = 1, tri_all = 0, sel_24 = 0;
  logic clk_cpu = 0, clk_apic = 0, clk_v66 = 0, clk_pci = 0, clk_ref = 0, clk_48 = 0;
  logic [3:0] cpu_en; logic [2:0] apic_en, v66_en; logic [10:0] pci_en;
  logic [1:0] ref_en; logic usb_en, mix_en;
  logic [15:0] wake_wait = 16'd4;
  wire [3:0] cpu_o; wire [2:0] apic_o, v66_o; wire [10:0] pci_o;
  wire [1:0] ref_o; wire usb_o, mix_o, vco_en, osc_en;
  wire [NT-1:0] outs = {mix_o, usb_o, ref_o, pci_o, v66_o, apic_o, cpu_o};

  always #2  clk_cpu  = ~clk_cpu;
  always #8  clk_apic = ~clk_apic;
  always #3  clk_v66  = ~clk_v66;
  always #4  clk_pci  = ~clk_pci;
  always #14 clk_ref  = ~clk_ref;
  always #10 clk_48   = ~clk_48;

  clk_out_gate dut (
    .rst_n(rst_n), .clk_cpu(clk_cpu), .clk_apic(clk_apic), .clk_v66(clk_v66),
    .clk_pci(clk_pci), .clk_ref(clk_ref), .clk_48(clk_48), .pd_n(pd_n),
    .cpu_en(cpu_en), .apic_en(apic_en), .v66_en(v66_en), .pci_en(pci_en),
    .ref_en(ref_en), .usb_en(usb_en), .mix_en(mix_en), .tri_all(tri_all),
    .sel_24(sel_24), .wake_wait(wake_wait), .cpu_o(cpu_o), .apic_o(apic_o),
    .v66_o(v66_o), .pci_o(pci_o), .ref_o(ref_o), .usb_o(usb_o), .mix_o(mix_o),
    .vco_en(vco_en), .osc_en(osc_en));

  int checks = 0, fails = 0;
  int rises[NT];
  bit hi[NT];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_mask(input logic [NT-1:0] m);
    {mix_en, usb_en, ref_en, pci_en, v66_en, apic_en, cpu_en} = m;
  endtask

  task automatic watch(input int ns);
    logic [NT-1:0] prev = outs;
    for (int i = 0; i < NT; i++) begin rises[i] = 0; hi[i] = 0; end
    for (int t = 0; t < ns; t++) begin
      #1;
      for (int i = 0; i < NT; i++) begin
        if (outs[i] === 1'b1) hi[i] = 1;
        if (outs[i] === 1'b1 && prev[i] !== 1'b1) rises[i]++;
      end
      prev = outs;
    end
  endtask

  task automatic check_pattern(input logic [NT-1:0] m, input string req);
    int bad_run = 0, bad_stop = 0;
    watch(140);
    for (int i = 0; i < NT; i++) begin
      if (m[i] && rises[i] < 2) bad_run++;
      if (!m[i] && hi[i]) bad_stop++;
    end
    chk(bad_run == 0, req, "enabled outputs not toggling", bad_run, 0);
    chk(bad_stop == 0, req, "masked outputs went high", bad_stop, 0);
  endtask

  task automatic power_down;
    int n = 0;
    pd_n = 0;
    while (vco_en && n < 2000) begin #1; n++; end
    chk(!vco_en, "R3", "vco_en never fell", vco_en, 0);
    chk(outs == '0, "R3", "outputs not parked at vco drop", outs, 0);
    chk(osc_en, "R3", "osc_en fell with vco_en", osc_en, 1);
    #8;
    chk(!osc_en, "R3", "osc_en one cycle after vco_en", osc_en, 0);
    watch(200);
    n = 0;
    for (int i = 0; i < NT; i++) if (hi[i]) n++;
    chk(n == 0, "R2", "outputs active in power-down", n, 0);
  endtask

  task automatic wake(input int w);
    int n = 0, t_any = -1, t_pci = -1;
    logic [NT-1:0] prev;
    wake_wait = 16'(w);
    pd_n = 1;
    while (!vco_en && n < 2000) begin #1; n++; end
    chk(vco_en && osc_en, "R4", "enables rise together", {vco_en, osc_en}, 3);
    prev = outs;
    for (int t = 1; t <= (w + 4) * 8; t++) begin
      #1;
      if (t_any < 0 && (outs & ~prev) != '0) t_any = t;
      if (t_pci < 0 && pci_o[0] && !prev[PC]) t_pci = t;
      prev = outs;
      if (t == t_pci) begin
        #3;
        chk(pci_o[0] === 1'b1, "R9", "first pulse width", pci_o[0], 1);
        t = t + 3;
        prev = outs;
      end
    end
    chk(t_any >= (w + 1) * 8, "R4", "early output after wake", t_any, (w + 1) * 8);
    chk(t_pci == (w + 2) * 8, "R4", "pci restart delay", t_pci, (w + 2) * 8);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    set_mask('1);
    #0.5;
    #40;
    chk(outs == '0, "R1", "outputs in reset", outs, 0);
    chk(!vco_en && !osc_en, "R1", "enables in reset", {vco_en, osc_en}, 0);
    rst_n = 1;
    #200;
    check_pattern('1, "R5");

    for (int k = 0; k < NT; k++) begin
      set_mask(~(NT'(1) << k));
      #60;
      check_pattern(~(NT'(1) << k), "R5");
      set_mask(NT'(1) << k);
      #60;
      check_pattern(NT'(1) << k, "R5");
    end
    set_mask('1);
    #60;

    @(posedge clk_pci); #0.5;
    pci_en[3] = 0;
    @(posedge clk_pci); @(posedge clk_pci); #0.5;
    chk(pci_o[3] === 1'b0, "R6", "disable latency", pci_o[3], 0);
    chk(pci_o[2] === 1'b1, "R6", "neighbour running", pci_o[2], 1);
    pci_en[3] = 1;
    @(posedge clk_pci); @(posedge clk_pci); #0.5;
    chk(pci_o[3] === 1'b1, "R6", "enable latency", pci_o[3], 1);
    #2.5;
    chk(pci_o[3] === 1'b1, "R9", "first pulse still high", pci_o[3], 1);
    #1.5;
    chk(pci_o[3] === 1'b0, "R9", "first pulse ends with source", pci_o[3], 0);

    tri_all = 1;
    watch(100);
    begin
      int n = 0;
      for (int i = 0; i < NT; i++) if (hi[i]) n++;
      chk(n == 0, "R7", "outputs driving while floated", n, 0);
    end
    chk(vco_en, "R7", "float leaves vco running", vco_en, 1);
    tri_all = 0;
    #20;
    check_pattern('1, "R7");

    mix_en = 0; sel_24 = 1; #60; mix_en = 1; #60;
    watch(400);
    chk(rises[NT-1] >= 9 && rises[NT-1] <= 11, "R8", "24 MHz rise count", rises[NT-1], 10);
    chk(rises[NT-2] >= 19 && rises[NT-2] <= 21, "R8", "48 MHz rise count", rises[NT-2], 20);
    mix_en = 0; sel_24 = 0; #60; mix_en = 1; #60;
    watch(400);
    chk(rises[NT-1] >= 19 && rises[NT-1] <= 21, "R8", "48 MHz on mixed output", rises[NT-1], 20);

    power_down();
    wake(3);
    #100;
    check_pattern('1, "R4");
    set_mask(25'h0F0F0F);
    #60;
    power_down();
    wake(12);
    #100;
    check_pattern(25'h0F0F0F, "R5");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule